// File: doc/BRIEF.md
# Triple Match Timer

This peripheral holds three identical 30-bit up-counters that all advance on the same 50 MHz clock. Each counter is steered by one control word holding an enable flag, a restart flag and a 30-bit match value, and it has a count register that software can load. When a running counter reaches its match value, the timer latches a pending flag. It then wraps to zero and keeps going, or it freezes where it is. That choice makes one timer suitable for a periodic tick and another for a free-running reference count.

A shared pending register is cleared by writing ones. A shared enable register picks which pending flags reach the single interrupt line. Software uses a plain word-addressed register port: one address, a write strobe, write data, and read data that is returned combinationally for whatever address is presented.

A typical setup loads the count with 0 and then writes a control word with the enable and restart flags set and a match value of 49999, which gives a 1 ms periodic event. A second timer with the restart flag clear and a match value of 0x3FFFFFFF serves as a long reference count that software reads directly.

Top module: `tri_match_timer`

## Requirements
- R1: After reset, every control word, count, pending bit and interrupt-enable bit reads 0, and `irqOut` is low.
- R2: The control word of timer i (i = 0..2) sits at word address i. Bit 31 is enable, bit 30 is restart, and bits 29:0 hold the match value. It reads back as written. While the enable bit is 0 the count does not change, so writing 0 halts the timer from the next cycle on.
- R3: An enabled, unstopped timer adds one to its count on every clock. The count is 30 bits wide and wraps from 0x3FFFFFFF to 0.
- R4: On a cycle where an enabled, unstopped timer's count equals its match value, its pending bit is set at the next edge. With restart = 1 the next count is 0, so the period is match + 1 clocks.
- R5: With restart = 0, the count freezes at the match value after a match and raises no further matches until software writes that timer's control or count register. A match value of 0x3FFFFFFF gives a free-running reference count that stops at the top.
- R6: The count register of timer i sits at word address 4 + i. A write loads data bits 29:0 and clears the stopped condition. A cycle that writes a timer's control or count register neither advances that timer nor matches it.
- R7: The pending register at address 8 holds bit i for timer i. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If a match and a clearing write to the same pending bit fall in one cycle, the bit stays set.
- R9: The interrupt-enable register at address 9 holds bit i for timer i. `irqOut` is high exactly when some pending bit is set and its enable bit is set, and it follows the registers with no extra delay.
- R10: Writes to unmapped addresses (3, 7, 10 to 15) change no register, and reads from them return 0. Unused upper bits of the pending and enable registers read as 0.
- R11: Programming or running one timer never changes the count of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz timebase and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Word address for read and write |
| busWr | input | 1 | Write strobe, sampled at the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Interrupt, OR of enabled pending bits |

## Verification
The checker watches several rules on every cycle. A count changes only by one, to zero, or through a bus write. A disabled timer keeps its count. A match always leaves its pending bit set, even when a clear write lands on the same cycle. A pending bit falls only after a write of 1 to that bit. The interrupt stays low when nothing enabled is pending. The periodic and stop-mode waveforms, the wrap at the 30-bit boundary, the reload that re-arms a stopped timer, the independence of the three channels and the handling of unmapped addresses can only be seen through the bench's scenarios. The bench sweeps every timer, both modes and a range of match values, and compares the count and pending readback each cycle against arithmetic expectations.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_TMR   = 3;
  localparam int CNT_W     = 30;
  localparam int DATA_W    = CNT_W + 2;
  localparam int ADDR_W    = 4;
  localparam int IDX_W     = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
  localparam int CNT_BASE  = 4;
  localparam int STS_ADDR  = 8;
  localparam int MASK_ADDR = 9;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTRL,
    RD_CNT,
    RD_STS,
    RD_MASK
  } rdKind_t;

  typedef struct packed {
    logic [NUM_TMR-1:0] ctrlWr;
    logic [NUM_TMR-1:0] cntWr;
    logic               stsWr;
    logic               maskWr;
    logic [DATA_W-1:0]  wrData;
    rdKind_t            rdKind;
    logic [IDX_W-1:0]   rdIdx;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic             cntWr,
  input  logic [CNT_W+1:0] wrData,
  output logic [CNT_W+1:0] ctrlQ,
  output logic [CNT_W-1:0] countQ,
  output logic             hit
);
  localparam int EN_BIT  = CNT_W + 1;
  localparam int RST_BIT = CNT_W;

  logic             stopped;
  logic             enable;
  logic             restart;
  logic [CNT_W-1:0] matchVal;
  logic             atMatch;
  logic             running;

  assign enable   = ctrlQ[EN_BIT];
  assign restart  = ctrlQ[RST_BIT];
  assign matchVal = ctrlQ[CNT_W-1:0];
  assign atMatch  = (countQ == matchVal);
  assign running  = enable && !stopped && !ctrlWr && !cntWr;
  assign hit      = running && atMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      countQ  <= '0;
      stopped <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ctrlQ <= wrData;
      end
      if (cntWr) begin
        countQ  <= wrData[CNT_W-1:0];
        stopped <= 1'b0;
      end else if (ctrlWr) begin
        stopped <= 1'b0;
      end else if (running) begin
        if (atMatch) begin
          if (restart) begin
            countQ <= '0;
          end else begin
            stopped <= 1'b1;
          end
        end else begin
          countQ <= countQ + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_regctl.sv
module tmr_regctl
  import tmr_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output tmrStrobe_t        strobe
);
  always_comb begin
    strobe        = '0;
    strobe.wrData = busWdata;
    strobe.rdKind = RD_NONE;
    strobe.rdIdx  = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (busAddr == ADDR_W'(i)) begin
        strobe.ctrlWr[i] = busWr;
        strobe.rdKind    = RD_CTRL;
        strobe.rdIdx     = IDX_W'(i);
      end
      if (busAddr == ADDR_W'(CNT_BASE + i)) begin
        strobe.cntWr[i] = busWr;
        strobe.rdKind   = RD_CNT;
        strobe.rdIdx    = IDX_W'(i);
      end
    end
    if (busAddr == ADDR_W'(STS_ADDR)) begin
      strobe.stsWr  = busWr;
      strobe.rdKind = RD_STS;
    end
    if (busAddr == ADDR_W'(MASK_ADDR)) begin
      strobe.maskWr = busWr;
      strobe.rdKind = RD_MASK;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  tmrStrobe_t                      strobe,
  output logic [DATA_W-1:0]               rdData,
  output logic                            irq,
  output logic [NUM_TMR-1:0][DATA_W-1:0]  ctrlVec,
  output logic [NUM_TMR-1:0][CNT_W-1:0]   countVec,
  output logic [NUM_TMR-1:0]              hitVec,
  output logic [NUM_TMR-1:0]              statusQ,
  output logic [NUM_TMR-1:0]              maskQ
);
  logic [NUM_TMR-1:0] clrBits;

  for (genvar g = 0; g < NUM_TMR; g++) begin : gChan
    tmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk    (clk),
      .rstN   (rstN),
      .ctrlWr (strobe.ctrlWr[g]),
      .cntWr  (strobe.cntWr[g]),
      .wrData (strobe.wrData),
      .ctrlQ  (ctrlVec[g]),
      .countQ (countVec[g]),
      .hit    (hitVec[g])
    );
  end

  assign clrBits = strobe.stsWr ? strobe.wrData[NUM_TMR-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~clrBits) | hitVec;
      if (strobe.maskWr) begin
        maskQ <= strobe.wrData[NUM_TMR-1:0];
      end
    end
  end

  assign irq = |(statusQ & maskQ);

  always_comb begin
    case (strobe.rdKind)
      RD_CTRL: rdData = ctrlVec[strobe.rdIdx];
      RD_CNT:  rdData = DATA_W'(countVec[strobe.rdIdx]);
      RD_STS:  rdData = DATA_W'(statusQ);
      RD_MASK: rdData = DATA_W'(maskQ);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut
);
  tmrStrobe_t                     strobe;
  logic [NUM_TMR-1:0][DATA_W-1:0] ctrlVec;
  logic [NUM_TMR-1:0][CNT_W-1:0]  countVec;
  logic [NUM_TMR-1:0]             hitVec;
  logic [NUM_TMR-1:0]             statusVec;
  logic [NUM_TMR-1:0]             maskVec;

  tmr_regctl u_regctl (
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .strobe   (strobe)
  );

  tmr_datapath u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdData   (busRdata),
    .irq      (irqOut),
    .ctrlVec  (ctrlVec),
    .countVec (countVec),
    .hitVec   (hitVec),
    .statusQ  (statusVec),
    .maskQ    (maskVec)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic                            clk,
  input logic                            rstN,
  input logic [ADDR_W-1:0]               busAddr,
  input logic                            busWr,
  input logic [DATA_W-1:0]               busWdata,
  input logic                            irqOut,
  input logic [NUM_TMR-1:0][DATA_W-1:0]  ctrlVec,
  input logic [NUM_TMR-1:0][CNT_W-1:0]   countVec,
  input logic [NUM_TMR-1:0]              hitVec,
  input logic [NUM_TMR-1:0]              statusVec,
  input logic [NUM_TMR-1:0]              maskVec
);
  // R9: nothing enabled and pending means no interrupt
  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (!rstN)
    ((statusVec & maskVec) == '0) |-> !irqOut);

  // R9: all enables clear keeps the line low
  a_r9_masked_irq: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |-> !irqOut);

  for (genvar g = 0; g < NUM_TMR; g++) begin : gChk
    // R4 and R8: a match always leaves the pending bit set
    a_r8_hit_sets: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[g] |=> statusVec[g]);

    // R7: a pending bit drops only after a write of one to it
    a_r7_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(statusVec[g]) |->
        $past(busWr && busAddr == ADDR_W'(STS_ADDR) && busWdata[g]));

    // R3: without a bus write a count steps by one or returns to zero
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(busWr) && countVec[g] != $past(countVec[g])) |->
        (countVec[g] == CNT_W'($past(countVec[g]) + 1'b1) || countVec[g] == '0));

    // R2: a disabled timer keeps its count
    a_r2_disabled_holds: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(ctrlVec[g][DATA_W-1]) && !$past(busWr)) |-> $stable(countVec[g]));
  end
endmodule

bind tri_match_timer tmr_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busWdata  (busWdata),
  .irqOut    (irqOut),
  .ctrlVec   (ctrlVec),
  .countVec  (countVec),
  .hitVec    (hitVec),
  .statusVec (statusVec),
  .maskVec   (maskVec)
);

// File: tb/tri_match_timer_bench.sv
module tri_match_timer_bench;
  localparam int CLK_PERIOD = 20;
  localparam logic [3:0] STS = 4'd8;
  localparam logic [3:0] MSK = 4'd9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  tri_match_timer u_tri_match_timer (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // call at a falling edge; the write lands at the next rising edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a;
    busWdata = d;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [31:0] cw(input bit en, input bit rs, input logic [29:0] m);
    return {en, rs, m};
  endfunction

  initial begin
    logic [31:0] v;
    logic [31:0] keep [3];
    logic [31:0] expC;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(irqOut == 1'b0, "R1 reset irq", {31'd0, irqOut}, 0);

    // R2: control readback
    wr(4'd1, cw(1'b0, 1'b1, 30'h2AAAAAAA));
    rd(4'd1, v);
    chk(v == cw(1'b0, 1'b1, 30'h2AAAAAAA), "R2 control readback", v, cw(1'b0, 1'b1, 30'h2AAAAAAA));
    wr(4'd1, 32'd0);

    // R3 R4 R5 R11 sweep over timers, modes and match values
    for (int t = 0; t < 3; t++) begin
      for (int mode = 0; mode < 2; mode++) begin
        for (int m = 0; m < 5; m++) begin
          wr(4'(4 + t), 32'd0);
          wr(STS, 32'h7);
          for (int o = 0; o < 3; o++) begin
            rd(4'(4 + o), keep[o]);
          end
          wr(4'(t), cw(1'b1, mode[0], 30'(m)));
          for (int k = 0; k < 13; k++) begin
            if (mode == 1) expC = 32'(k % (m + 1));
            else expC = 32'((k < m) ? k : m);
            rd(4'(4 + t), v);
            chk(v == expC, mode == 1 ? "R4 restart count" : "R5 stop count", v, expC);
            rd(STS, v);
            chk(v[t] == (k >= m + 1), "R4 pending set", {31'd0, v[t]}, {31'd0, k >= m + 1});
            @(negedge clk);
          end
          for (int o = 0; o < 3; o++) begin
            if (o != t) begin
              rd(4'(4 + o), v);
              chk(v == keep[o], "R11 other timer untouched", v, keep[o]);
            end
          end
          // R2: writing zero halts at once
          wr(4'(t), 32'd0);
          rd(4'(4 + t), held);
          repeat (3) @(negedge clk);
          rd(4'(4 + t), v);
          chk(v == held, "R2 halt holds count", v, held);
        end
      end
    end

    // R3 R6: wrap at the 30-bit boundary after a count load
    wr(4'd5, 32'h3FFFFFFE);
    wr(STS, 32'h7);
    wr(4'd1, cw(1'b1, 1'b1, 30'd5));
    for (int k = 0; k < 10; k++) begin
      if (k <= 7) expC = {2'b00, 30'(30'h3FFFFFFE + 30'(k))};
      else expC = 32'(k - 8);
      rd(4'd5, v);
      chk(v == expC, "R3 wrap count", v, expC);
      rd(STS, v);
      chk(v[1] == (k >= 8), "R4 pending after wrap", {31'd0, v[1]}, {31'd0, k >= 8});
      @(negedge clk);
    end
    wr(4'd1, 32'd0);

    // R5: free-running reference stops at the top
    wr(4'd6, 32'h3FFFFFFD);
    wr(STS, 32'h7);
    wr(4'd2, cw(1'b1, 1'b0, 30'h3FFFFFFF));
    for (int k = 0; k < 7; k++) begin
      expC = (k < 2) ? 32'h3FFFFFFD + 32'(k) : 32'h3FFFFFFF;
      rd(4'd6, v);
      chk(v == expC, "R5 reference count", v, expC);
      @(negedge clk);
    end
    rd(STS, v);
    chk(v[2] == 1'b1, "R5 reference pending", {31'd0, v[2]}, 1);
    // R6: reloading the count re-arms the stopped timer
    wr(4'd6, 32'd0);
    for (int k = 0; k < 3; k++) begin
      rd(4'd6, v);
      chk(v == 32'(k), "R6 reload restarts", v, 32'(k));
      @(negedge clk);
    end
    wr(4'd2, 32'd0);

    // R9: interrupt enables
    wr(STS, 32'h7);
    wr(4'd4, 32'd0);
    wr(4'd0, cw(1'b1, 1'b1, 30'd3));
    repeat (6) @(negedge clk);
    chk(irqOut == 1'b0, "R9 masked irq low", {31'd0, irqOut}, 0);
    wr(MSK, 32'h1);
    chk(irqOut == 1'b1, "R9 enabled irq high", {31'd0, irqOut}, 1);
    wr(MSK, 32'h6);
    chk(irqOut == 1'b0, "R9 other enables only", {31'd0, irqOut}, 0);
    rd(MSK, v);
    chk(v == 32'h6, "R10 enable upper bits zero", v, 32'h6);
    wr(4'd0, 32'd0);

    // R7: write-one-to-clear, zeros ignored
    wr(STS, 32'h7);
    wr(4'd4, 32'd0);
    wr(4'd6, 32'd0);
    wr(4'd0, cw(1'b1, 1'b0, 30'd1));
    wr(4'd2, cw(1'b1, 1'b0, 30'd1));
    repeat (4) @(negedge clk);
    rd(STS, v);
    chk(v == 32'h5, "R7 both pending", v, 32'h5);
    wr(STS, 32'h1);
    rd(STS, v);
    chk(v == 32'h4, "R7 clear one bit", v, 32'h4);
    wr(STS, 32'h0);
    rd(STS, v);
    chk(v == 32'h4, "R7 zero write no effect", v, 32'h4);
    chk(irqOut == 1'b1, "R9 irq on timer 2", {31'd0, irqOut}, 1);
    wr(4'd0, 32'd0);
    wr(4'd2, 32'd0);

    // R8: match and clear in the same cycle
    wr(STS, 32'h7);
    wr(4'd4, 32'd0);
    wr(4'd0, cw(1'b1, 1'b1, 30'd0));
    @(negedge clk);
    wr(STS, 32'h1);
    rd(STS, v);
    chk(v[0] == 1'b1, "R8 match beats clear", {31'd0, v[0]}, 1);
    wr(4'd0, 32'd0);
    wr(STS, 32'h7);
    rd(STS, v);
    chk(v == 0, "R7 clear after halt", v, 0);

    // R10: unmapped addresses
    wr(4'd0, cw(1'b0, 1'b0, 30'h123));
    wr(MSK, 32'h2);
    wr(4'd3, 32'hFFFFFFFF);
    wr(4'd7, 32'hFFFFFFFF);
    for (int a = 10; a < 16; a++) wr(4'(a), 32'hFFFFFFFF);
    rd(4'd0, v);
    chk(v == 32'h123, "R10 control unchanged", v, 32'h123);
    rd(MSK, v);
    chk(v == 32'h2, "R10 enable unchanged", v, 32'h2);
    rd(STS, v);
    chk(v == 32'h0, "R10 pending unchanged", v, 0);
    rd(4'd3, v);
    chk(v == 0, "R10 unmapped reads zero", v, 0);
    rd(4'd12, v);
    chk(v == 0, "R10 high unmapped reads zero", v, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule